// File: doc/BRIEF.md
# Slow-Motion Decode/Display Interlock

This block sits between a picture decoder and an interlaced display controller during slow-motion playback. When slow motion is enabled, it lets the decoder run until the current picture unit is complete, then stalls it and holds one field on screen. In field mode every decoded field ends a picture unit. In frame mode only the field that ends a frame does. While the picture is frozen, the host can step the held field to the other parity, or resume normal decoding, which restarts at the next vertical blanking interval.

The second job of the block is the memory interlock for B pictures. Reconstruction of a B frame reuses the buffer area that still holds the last field of the previous frame. The block therefore tracks, at every vertical sync, which field the display shows and how many more display periods remain for it. It grants the start of reconstruction only once that last field has entered its final display period. This interlock is independent of the freeze logic and stays active in slow motion.

Top module: `slomo_interlock`

## Requirements
- R1: After reset `dec_run`=1, `frz_on`=0, `frz_par`=0 and `recon_go`=0.
- R2: In field mode (`frame_mode`=0) with `slomo_en`=1, a `pu_done` pulse while running makes `dec_run`=0 and `frz_on`=1 from the following cycle.
- R3: In frame mode (`frame_mode`=1) a `pu_done` with `pu_last`=0 has no effect, and one with `pu_last`=1 freezes as in R2.
- R4: With `slomo_en`=0, `pu_done` never stops the decoder.
- R5: On freezing, `frz_par` takes the parity on display (`vs_par` of the latest `vsync`, or of a `vsync` in the same cycle). Parity 0 means odd/top and 1 means even/bottom.
- R6: A `step_cmd` while frozen inverts `frz_par` in the cycle after the next `vsync` pulse. `frz_par` changes at no other time while frozen or resuming.
- R7: A `step_cmd` that arrives while a step is already pending, including in the cycle of the `vsync` that consumes it, is ignored, so at most one inversion occurs per `vsync`.
- R8: A `resume_cmd` while frozen discards any pending step. `dec_run` returns to 1 in the cycle after the next `vsync`, and `frz_on` falls at the same time. `step_cmd` has no effect while resuming.
- R9: At a `vsync` with `fld_first`=1 the remaining-repeat count loads `fld_rpt` and the last-field flag loads `fld_last`. At a `vsync` with `fld_first`=0 the count decrements and saturates at 0. The final display period is the last-field flag set with a count of 0.
- R10: `recon_go` rises in the cycle after an edge where `b_pend`=1 and the final display period holds, including the `vsync` edge that establishes it, and never earlier.
- R11: Once granted, `recon_go` stays 1 while `b_pend`=1 across later vsyncs, and falls in the cycle after `b_pend`=0.
- R12: The grant operates identically whether the decoder is running, frozen or resuming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slomo_en | input | 1 | Slow-motion mode enable |
| frame_mode | input | 1 | 1 = frame picture units, 0 = field picture units |
| pu_done | input | 1 | Decoder finished a field (pulse) |
| pu_last | input | 1 | With pu_done: that field ends a frame |
| vsync | input | 1 | Vertical sync, one-cycle pulse per display period |
| vs_par | input | 1 | Parity of the field shown from this vsync |
| fld_first | input | 1 | With vsync: this period starts a new field |
| fld_last | input | 1 | With vsync and fld_first: field is last of its frame |
| fld_rpt | input | RPT_W | With vsync and fld_first: further repeat periods |
| step_cmd | input | 1 | Host step to opposite field |
| resume_cmd | input | 1 | Host release of freeze |
| b_pend | input | 1 | A B-frame reconstruction is waiting |
| dec_run | output | 1 | 1 = decoder may run, 0 = stalled |
| frz_on | output | 1 | Freeze or resume wait in progress |
| frz_par | output | 1 | Parity of the held field |
| recon_go | output | 1 | B-frame reconstruction start grant |

## Verification
The embedded assertions check on every cycle that a picture-unit boundary in slow motion stalls the decoder, and that the held parity moves only at a vsync with a pending step. They also check that a resume never completes without a vsync, that the repeat count steps down by one, and that the grant never rises without the final-period condition and never outlives `b_pend`. Only the bench's scenarios can show the end-to-end orderings. These include the exact parity captured when the freeze coincides with a vsync, the loss of surplus step commands, and the frame-mode boundary filtering. They also include the count of vsyncs after which the grant appears for a given repeat setting, and the grant behaving the same while frozen.

// File: rtl/slomo_pkg.sv
package slomo_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_FROZEN = 2'd1,
    ST_RESUME = 2'd2
  } frz_state_e;

  // Picture-unit boundary: every field in field mode, frame end in frame mode.
  function automatic logic pu_boundary(input logic frame_mode,
                                       input logic done,
                                       input logic last);
    return done && (!frame_mode || last);
  endfunction

  // Grant recurrence: hold while pending, open once the final period is seen.
  function automatic logic grant_next(input logic pend,
                                      input logic held,
                                      input logic final_now);
    return pend && (held || final_now);
  endfunction

endpackage

// File: rtl/slomo_disp_trk.sv
module slomo_disp_trk #(
  parameter int RPT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync,
  input  logic             vs_par,
  input  logic             fld_first,
  input  logic             fld_last,
  input  logic [RPT_W-1:0] fld_rpt,
  output logic             disp_par_now,
  output logic             fin_now,
  output logic [RPT_W-1:0] rpt_left
);

  localparam logic [RPT_W-1:0] RPT_ZERO = '0;

  function automatic logic [RPT_W-1:0] dec_sat(input logic [RPT_W-1:0] v);
    return (v == RPT_ZERO) ? RPT_ZERO : v - 1'b1;
  endfunction

  logic [RPT_W-1:0] rc_q, rc_nx;
  logic             lf_q, lf_nx;
  logic             par_q;

  always_comb begin
    rc_nx = rc_q;
    lf_nx = lf_q;
    if (vsync) begin
      if (fld_first) begin
        rc_nx = fld_rpt;
        lf_nx = fld_last;
      end else begin
        rc_nx = dec_sat(rc_q);
      end
    end
  end

  assign fin_now      = lf_nx && (rc_nx == RPT_ZERO);
  assign disp_par_now = vsync ? vs_par : par_q;
  assign rpt_left     = rc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q  <= RPT_ZERO;
      lf_q  <= 1'b0;
      par_q <= 1'b0;
    end else begin
      rc_q  <= rc_nx;
      lf_q  <= lf_nx;
      par_q <= disp_par_now;
    end
  end

  // R9: a repeat period consumes exactly one count
  a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !fld_first && rc_q != RPT_ZERO) |=> (rc_q == $past(rc_q) - 1'b1));

  // R9: a new field loads its repeat count
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && fld_first) |=> (rc_q == $past(fld_rpt)));

endmodule

// File: rtl/slomo_freeze_fsm.sv
module slomo_freeze_fsm
  import slomo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slomo_en,
  input  logic frame_mode,
  input  logic pu_done,
  input  logic pu_last,
  input  logic vsync,
  input  logic disp_par_now,
  input  logic step_cmd,
  input  logic resume_cmd,
  output logic dec_run,
  output logic frz_on,
  output logic frz_par
);

  frz_state_e st_q, st_nx;
  logic       step_pend_q, step_pend_nx;
  logic       par_q, par_nx;
  logic       pu_edge;
  logic       step_fire;

  assign pu_edge   = slomo_en && pu_boundary(frame_mode, pu_done, pu_last);
  assign step_fire = (st_q == ST_FROZEN) && vsync && step_pend_q;

  always_comb begin
    st_nx        = st_q;
    step_pend_nx = step_pend_q;
    par_nx       = par_q;
    case (st_q)
      ST_RUN: begin
        step_pend_nx = 1'b0;
        if (pu_edge) begin
          st_nx  = ST_FROZEN;
          par_nx = disp_par_now;
        end
      end
      ST_FROZEN: begin
        if (resume_cmd) begin
          st_nx        = ST_RESUME;
          step_pend_nx = 1'b0;
        end else if (step_fire) begin
          par_nx       = ~par_q;
          step_pend_nx = 1'b0;
        end else if (step_cmd) begin
          step_pend_nx = 1'b1;
        end
      end
      ST_RESUME: begin
        step_pend_nx = 1'b0;
        if (vsync) st_nx = ST_RUN;
      end
      default: begin
        st_nx        = ST_RUN;
        step_pend_nx = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      step_pend_q <= 1'b0;
      par_q       <= 1'b0;
    end else begin
      st_q        <= st_nx;
      step_pend_q <= step_pend_nx;
      par_q       <= par_nx;
    end
  end

  assign dec_run = (st_q == ST_RUN);
  assign frz_on  = (st_q != ST_RUN);
  assign frz_par = par_q;

  // R2: a slow-motion boundary stalls the decoder on the next cycle
  a_r2_stop_at_pu: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_run && pu_edge) |=> !dec_run);

  // R4: without slow motion the decoder is never stalled by a boundary
  a_r4_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_run && !slomo_en) |=> dec_run);

  // R6: held parity moves only at a vsync while frozen
  a_r6_par_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_on && !vsync) |=> $stable(frz_par));

  // R7: at most one parity flip per vsync, and only with a pending step
  a_r7_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_on && !step_fire) |=> $stable(frz_par));

  // R8: resume completes only on a vsync
  a_r8_resume_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESUME && !vsync) |=> !dec_run);

endmodule

// File: rtl/slomo_recon_gate.sv
module slomo_recon_gate
  import slomo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic b_pend,
  input  logic fin_now,
  output logic recon_go
);

  logic go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else        go_q <= grant_next(b_pend, go_q, fin_now);
  end

  assign recon_go = go_q;

  // R10: the grant never opens before the last field's final period
  a_r10_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recon_go) |-> $past(b_pend && fin_now));

  // R11: the grant never outlives the request
  a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !b_pend |=> !recon_go);

  // R11: an open grant is kept while the request stays
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_go && b_pend) |=> recon_go);

endmodule

// File: rtl/slomo_interlock.sv
module slomo_interlock
  import slomo_pkg::*;
#(
  parameter int RPT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slomo_en,
  input  logic             frame_mode,
  input  logic             pu_done,
  input  logic             pu_last,
  input  logic             vsync,
  input  logic             vs_par,
  input  logic             fld_first,
  input  logic             fld_last,
  input  logic [RPT_W-1:0] fld_rpt,
  input  logic             step_cmd,
  input  logic             resume_cmd,
  input  logic             b_pend,
  output logic             dec_run,
  output logic             frz_on,
  output logic             frz_par,
  output logic             recon_go
);

  logic             disp_par_now;
  logic             fin_now;
  logic [RPT_W-1:0] rpt_left;

  slomo_disp_trk #(.RPT_W(RPT_W)) trk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync        (vsync),
    .vs_par       (vs_par),
    .fld_first    (fld_first),
    .fld_last     (fld_last),
    .fld_rpt      (fld_rpt),
    .disp_par_now (disp_par_now),
    .fin_now      (fin_now),
    .rpt_left     (rpt_left)
  );

  slomo_freeze_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .slomo_en     (slomo_en),
    .frame_mode   (frame_mode),
    .pu_done      (pu_done),
    .pu_last      (pu_last),
    .vsync        (vsync),
    .disp_par_now (disp_par_now),
    .step_cmd     (step_cmd),
    .resume_cmd   (resume_cmd),
    .dec_run      (dec_run),
    .frz_on       (frz_on),
    .frz_par      (frz_par)
  );

  slomo_recon_gate gate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .b_pend   (b_pend),
    .fin_now  (fin_now),
    .recon_go (recon_go)
  );

  // R10: an open grant implies the remaining count reached zero at some vsync
  a_r10_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recon_go) |-> (rpt_left == '0));

  // R1/R8: run and freeze flags are complementary
  a_r8_flags: assert property (@(posedge clk) disable iff (!rst_n)
    dec_run != frz_on);

endmodule

// File: tb/slomo_interlock_tb_top.sv
module slomo_interlock_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RPT_W      = 4;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slomo_en = 0, frame_mode = 0, pu_done = 0, pu_last = 0;
  logic vsync = 0, vs_par = 0, fld_first = 0, fld_last = 0;
  logic [RPT_W-1:0] fld_rpt = '0;
  logic step_cmd = 0, resume_cmd = 0, b_pend = 0;
  logic dec_run, frz_on, frz_par, recon_go;

  always #(CLK_PERIOD/2) clk = ~clk;

  slomo_interlock #(.RPT_W(RPT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slomo_en(slomo_en), .frame_mode(frame_mode),
    .pu_done(pu_done), .pu_last(pu_last), .vsync(vsync), .vs_par(vs_par),
    .fld_first(fld_first), .fld_last(fld_last), .fld_rpt(fld_rpt),
    .step_cmd(step_cmd), .resume_cmd(resume_cmd), .b_pend(b_pend),
    .dec_run(dec_run), .frz_on(frz_on), .frz_par(frz_par), .recon_go(recon_go)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // Behavioural reference: 0 running, 1 held, 2 waiting for vsync to run
  int mode_m = 0;
  int held_par = 0, shown_par = 0, step_m = 0;
  int left_m = 0, lastf_m = 0, go_m = 0;

  always @(posedge clk) begin
    int shown, left, lastf, fin;
    if (!rst_n) begin
      mode_m = 0; held_par = 0; shown_par = 0; step_m = 0;
      left_m = 0; lastf_m = 0; go_m = 0;
    end else begin
      shown = vsync ? int'(vs_par) : shown_par;
      left = left_m; lastf = lastf_m;
      if (vsync) begin
        if (fld_first) begin left = int'(fld_rpt); lastf = int'(fld_last); end
        else if (left > 0) left = left - 1;
      end
      fin = (lastf == 1 && left == 0) ? 1 : 0;
      go_m = (b_pend && (go_m == 1 || fin == 1)) ? 1 : 0;
      if (mode_m == 0) begin
        step_m = 0;
        if (slomo_en && pu_done && (frame_mode ? pu_last : 1'b1)) begin
          mode_m = 1; held_par = shown;
        end
      end else if (mode_m == 1) begin
        if (resume_cmd) begin mode_m = 2; step_m = 0; end
        else if (vsync && step_m == 1) begin held_par = 1 - held_par; step_m = 0; end
        else if (step_cmd) step_m = 1;
      end else begin
        step_m = 0;
        if (vsync) mode_m = 0;
      end
      shown_par = shown; left_m = left; lastf_m = lastf;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "dec_run", int'(dec_run), (mode_m == 0) ? 1 : 0);
      chk(cur_req, "frz_on", int'(frz_on), (mode_m != 0) ? 1 : 0);
      chk(cur_req, "frz_par", int'(frz_par), held_par);
      chk(cur_req, "recon_go", int'(recon_go), go_m);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic vs(input logic p, input logic first, input logic last, input int rpt);
    vsync = 1; vs_par = p; fld_first = first; fld_last = last; fld_rpt = RPT_W'(rpt);
    cyc(1);
    vsync = 0; fld_first = 0; fld_last = 0; fld_rpt = '0;
  endtask

  task automatic pulse_pu(input logic last);
    pu_done = 1; pu_last = last; cyc(1); pu_done = 0; pu_last = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      cnt++;
      if (cnt > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cnt, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    cur_req = "R1";
    chk("R1", "reset dec_run", int'(dec_run), 1);
    chk("R1", "reset frz_on", int'(frz_on), 0);
    chk("R1", "reset frz_par", int'(frz_par), 0);
    chk("R1", "reset recon_go", int'(recon_go), 0);

    // R4: slow motion off
    cur_req = "R4";
    vs(1, 1, 0, 0);
    pulse_pu(1); pulse_pu(0);
    chk("R4", "no stall", int'(dec_run), 1);

    // R2 / R5: field mode freeze captures shown parity 1
    cur_req = "R2";
    slomo_en = 1; frame_mode = 0;
    cyc(2);
    pulse_pu(0);
    chk("R2", "stalled", int'(dec_run), 0);
    chk("R5", "held parity", int'(frz_par), 1);

    // R6 / R7: three step commands, one flip per vsync
    cur_req = "R7";
    step_cmd = 1; cyc(3); step_cmd = 0;
    cyc(2);
    chk("R6", "no flip before vsync", int'(frz_par), 1);
    vs(0, 0, 0, 0);
    chk("R6", "flip at vsync", int'(frz_par), 0);
    vs(1, 0, 0, 0);
    chk("R7", "extra steps ignored", int'(frz_par), 0);
    // step in the same cycle as the consuming vsync is dropped
    step_cmd = 1; cyc(1); step_cmd = 0; cyc(1);
    step_cmd = 1; vs(0, 0, 0, 0); step_cmd = 0;
    chk("R7", "flip once", int'(frz_par), 1);
    vs(1, 0, 0, 0);
    chk("R7", "coincident step dropped", int'(frz_par), 1);

    // R8: resume discards pending step, runs after next vsync
    cur_req = "R8";
    step_cmd = 1; cyc(1); step_cmd = 0;
    resume_cmd = 1; cyc(1); resume_cmd = 0;
    step_cmd = 1; cyc(2); step_cmd = 0;
    chk("R8", "still stalled", int'(dec_run), 0);
    vs(0, 0, 0, 0);
    chk("R8", "running", int'(dec_run), 1);
    chk("R8", "step discarded", int'(frz_par), 1);

    // R5: freeze coincident with vsync of parity 0
    cur_req = "R5";
    pu_done = 1; vsync = 1; vs_par = 0; cyc(1);
    pu_done = 0; vsync = 0;
    chk("R5", "coincident parity", int'(frz_par), 0);
    resume_cmd = 1; cyc(1); resume_cmd = 0; vs(1, 0, 0, 0);

    // R3: frame mode filters non-final fields
    cur_req = "R3";
    frame_mode = 1;
    pulse_pu(0); cyc(1);
    chk("R3", "mid-frame ignored", int'(dec_run), 1);
    pulse_pu(1);
    chk("R3", "frame end stalls", int'(dec_run), 0);
    resume_cmd = 1; cyc(1); resume_cmd = 0; vs(0, 0, 0, 0);

    // R9 / R10: grant after repeats run out on last field
    cur_req = "R10";
    b_pend = 1;
    vs(1, 1, 1, 2); cyc(2);
    chk("R10", "count 2 no grant", int'(recon_go), 0);
    vs(0, 0, 0, 0); cyc(2);
    chk("R9", "count 1 no grant", int'(recon_go), 0);
    vs(0, 0, 0, 0);
    chk("R10", "grant", int'(recon_go), 1);

    // R11: hold across vsyncs, drop with request
    cur_req = "R11";
    vs(1, 1, 0, 3); vs(0, 0, 0, 0);
    chk("R11", "held", int'(recon_go), 1);
    b_pend = 0; cyc(1);
    chk("R11", "dropped", int'(recon_go), 0);

    // R10: not last field, count zero, no grant
    cur_req = "R10";
    b_pend = 1;
    vs(1, 1, 0, 0); cyc(3);
    chk("R10", "not last field", int'(recon_go), 0);
    b_pend = 0;
    // final period already established, request arrives later
    vs(0, 1, 1, 0); cyc(2);
    b_pend = 1; cyc(1);
    chk("R10", "late request", int'(recon_go), 1);
    b_pend = 0; cyc(1);

    // R12: grant while frozen, saturation of count
    cur_req = "R12";
    frame_mode = 0;
    pulse_pu(0);
    chk("R12", "frozen", int'(frz_on), 1);
    b_pend = 1;
    vs(1, 1, 1, 1); cyc(1);
    chk("R12", "no grant yet", int'(recon_go), 0);
    vs(0, 0, 0, 0);
    chk("R12", "grant while frozen", int'(recon_go), 1);
    vs(1, 0, 0, 0); vs(0, 0, 0, 0);
    chk("R9", "saturated count keeps grant", int'(recon_go), 1);
    b_pend = 0; cyc(2);

    // R1: reset mid-operation
    cur_req = "R1";
    rst_n = 0; cyc(2);
    rst_n = 1; cyc(1);
    chk("R1", "reset dec_run", int'(dec_run), 1);
    chk("R1", "reset frz_par", int'(frz_par), 0);
    chk("R1", "reset recon_go", int'(recon_go), 0);
    cyc(2);
    finish_run();
  end

endmodule